// File: doc/BRIEF.md
# Sequential Signed Nonrestoring Divider

This block divides a signed dividend by a positive divisor, one radix-2 iteration per clock. The dividend `x_i` is an (N+1)-bit two's complement value that must satisfy −Y ≤ X < Y. The divisor `y_i` is an N-bit value greater than zero. Each iteration doubles the partial remainder. It then subtracts the divisor when that remainder is non-negative and adds it when the remainder is negative. A single adder/subtractor serves every iteration and also the closing fix-up step.

After P iterations, one correction cycle aligns the sign of the remainder with the sign of the dividend. That cycle moves the quotient by one and the remainder by one divisor when needed. The result satisfies X·2^P = Q·Y + R, so Q is a (P+1)-bit two's complement fixed-point ratio with P fraction bits. A caller pulses `start_i` while the block is idle and then waits for the one-cycle `done_o` pulse. The operands are captured at start, so they may change while the division runs.

Top module: `nrdiv_seq`

## Requirements
- R1: `start_i` is accepted only while `busy_o` is low; an accepted start raises `busy_o` in the next cycle.
- R2: `done_o` is high for exactly one cycle, P+2 cycles after the cycle in which start was accepted, and `busy_o` is low whenever `done_o` is high.
- R3: For every legal operand pair (0 < Y < 2^N, −Y ≤ X < Y), the outputs satisfy X·2^P = Q·Y + R, where Q is `quot_o` read as a signed (P+1)-bit value and R is `rem_o` read as a signed (N+1)-bit value.
- R4: For X ≥ 0 the remainder lies in 0 ≤ R < Y.
- R5: For X < 0 the remainder lies in −Y ≤ R < 0, so a zero remainder is reported as −Y with the quotient one higher.
- R6: Operands are registered when start is accepted; changes on `x_i` and `y_i` while busy have no effect on the result.
- R7: A start pulse while busy is ignored: the running result is unaffected and no second operation follows.
- R8: `quot_o` and `rem_o` change only in the cycle in which `done_o` rises, and hold their values otherwise.
- R9: After reset, `busy_o`, `done_o`, `quot_o` and `rem_o` are all zero.
- R10: The extreme operands give fixed results: X = 0 yields Q = 0, R = 0; X = −Y yields Q = −2^P + 1, R = −Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division (sampled only while idle) |
| x_i | input | N+1 | Signed dividend, −Y ≤ X < Y |
| y_i | input | N | Positive divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quot_o | output | P+1 | Signed quotient, X·2^P = Q·Y + R |
| rem_o | output | N+1 | Signed remainder, sign follows the dividend |

## Verification
The bench sweeps every legal dividend for every divisor of a four-bit configuration. This exercises both correction directions. A design that swapped the increment and decrement, or added Y where it should subtract, breaks the Q·Y + R identity or leaves R with the wrong sign. The sweep covers the extremes X = −Y and X = 0 and the negative dividends whose true remainder is zero. These are where a missing forced least significant quotient bit, or a correction that tests R ≠ 0 instead of the sign, returns a result one off. Other runs scramble the operand pins and pulse start mid-operation. A design that did not hold its operands, or that restarted on a busy start, would return a result for the new operands or raise a second done pulse.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
  parameter int N = 8
) (
  input  logic [N:0]   a_i,
  input  logic [N-1:0] b_i,
  input  logic         en_i,
  input  logic         sub_i,
  output logic [N:0]   r_o
);
  logic [N:0] b_ext;
  assign b_ext = {1'b0, b_i};

  always_comb begin
    if (!en_i)      r_o = a_i;
    else if (sub_i) r_o = a_i - b_ext;
    else            r_o = a_i + b_ext;
  end
endmodule

// File: rtl/nrdiv_qfix.sv
module nrdiv_qfix #(
  parameter int P = 8
) (
  input  logic [P:0] q_i,
  input  logic       inc_i,
  input  logic       dec_i,
  output logic [P:0] q_o
);
  logic [P:0] inc_ext, dec_ext;
  assign inc_ext = {{P{1'b0}}, inc_i};
  assign dec_ext = {{P{1'b0}}, dec_i};
  assign q_o     = q_i + inc_ext - dec_ext;
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int P = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(P + 1);

  nrdiv_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIX);
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == CW'(P - 1)) state_q <= ST_FIX;
          else                     cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_START_TO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R2
  AST_FIX_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_o |-> $past(step_o)); // R2
endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq #(
  parameter int N = 8,
  parameter int P = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N:0]   x_i,
  input  logic [N-1:0] y_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [P:0]   quot_o,
  output logic [N:0]   rem_o
);
  logic load, step, fix;
  logic [N:0]   rem_q, as_a, as_r;
  logic [N-1:0] y_q;
  logic         xneg_q;
  logic [P:0]   quo_q, q_fixed;
  logic         as_en, as_sub, fix_inc, fix_dec;

  nrdiv_ctrl #(.P(P)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fix_o  (fix),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  // one adder: iteration step while running, sign fix-up in the last cycle
  assign fix_inc = xneg_q && !rem_q[N];
  assign fix_dec = !xneg_q && rem_q[N];
  assign as_a    = step ? {rem_q[N-1:0], 1'b0} : rem_q;
  assign as_en   = step || fix_inc || fix_dec;
  assign as_sub  = step ? !rem_q[N] : fix_inc;

  nrdiv_addsub #(.N(N)) u_addsub (
    .a_i  (as_a),
    .b_i  (y_q),
    .en_i (as_en),
    .sub_i(as_sub),
    .r_o  (as_r)
  );

  // lsb of the raw quotient is forced to one
  nrdiv_qfix #(.P(P)) u_qfix (
    .q_i  ({quo_q[P:1], 1'b1}),
    .inc_i(fix_inc),
    .dec_i(fix_dec),
    .q_o  (q_fixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      y_q    <= '0;
      xneg_q <= 1'b0;
      quo_q  <= '0;
      quot_o <= '0;
      rem_o  <= '0;
    end else if (load) begin
      rem_q  <= x_i;
      y_q    <= y_i;
      xneg_q <= x_i[N];
      quo_q  <= {{P{1'b0}}, x_i[N]};
    end else if (step) begin
      rem_q <= as_r;
      quo_q <= {quo_q[P-1:0], !as_r[N]};
    end else if (fix) begin
      quot_o <= q_fixed;
      rem_o  <= as_r;
    end
  end

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> ($signed(rem_q) < $signed({1'b0, y_q}) &&
              $signed(rem_q) >= -$signed({1'b0, y_q}))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quot_o) && $stable(rem_o))); // R8
  AST_REM_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix |=> (rem_o[N] == xneg_q)); // R4
endmodule

// File: tb/tb_nrdiv_seq.sv
module tb_nrdiv_seq;
  localparam int N = 4;
  localparam int P = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N:0]   x_in = '0;
  logic [N-1:0] y_in = '0;
  logic         busy, done;
  logic [P:0]   quot;
  logic [N:0]   rem;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  nrdiv_seq #(.N(N), .P(P)) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .x_i    (x_in),
    .y_i    (y_in),
    .busy_o (busy),
    .done_o (done),
    .quot_o (quot),
    .rem_o  (rem)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 scramble operands while busy, 2 extra start while busy
  task automatic run(input int x, input int y, input int mode, input bit verbose);
    int num, q0, r0, eq, er, lat, aq, ar;
    bit seen;
    num = x * (1 << P);
    q0 = num / y;
    if ((num % y) != 0 && num < 0) q0 = q0 - 1;
    r0 = num - q0 * y;
    if (x >= 0) begin eq = q0; er = r0; end
    else begin eq = q0 + 1; er = r0 - y; end

    @(negedge clk);
    x_in = x[N:0];
    y_in = y[N-1:0];
    start = 1'b1;
    lat = 0;
    seen = 1'b0;
    while (!seen && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        start = 1'b0;
        if (verbose) chk("R1 busy after start", int'(busy), 1);
      end
      if (mode == 1 && lat == 2) begin
        x_in = ~x_in;
        y_in = ~y_in;
      end
      if (mode == 2 && lat == 2) begin
        start = 1'b1;
        x_in = '0;
        y_in = 4'd1;
      end
      if (mode == 2 && lat == 3) start = 1'b0;
      seen = done;
    end
    aq = int'($signed(quot));
    ar = int'($signed(rem));
    if (verbose) begin
      chk("R2 latency", lat, P + 2);
      chk("R2 not busy at done", int'(busy), 0);
    end
    if (mode == 1) begin
      chk("R6 quotient", aq, eq);
      chk("R6 remainder", ar, er);
    end else if (mode == 2) begin
      chk("R7 quotient", aq, eq);
      chk("R7 remainder", ar, er);
    end else begin
      checks++;
      if (aq != eq || ar != er || aq * y + ar != num) begin
        fails++;
        $display("FAIL R3 x=%0d y=%0d: act q=%0d r=%0d exp q=%0d r=%0d", x, y, aq, ar, eq, er);
      end
      checks++;
      if (x >= 0 && !(ar >= 0 && ar < y)) begin
        fails++;
        $display("FAIL R4 x=%0d y=%0d: act r=%0d exp 0..%0d", x, y, ar, y - 1);
      end
      if (x < 0 && !(ar >= -y && ar < 0)) begin
        fails++;
        $display("FAIL R5 x=%0d y=%0d: act r=%0d exp %0d..-1", x, y, ar, -y);
      end
    end
  endtask

  initial begin
    int hq, hr, extra;
    // R9 reset state
    #1;
    chk("R9 busy", int'(busy), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 quot", int'(quot), 0);
    chk("R9 rem", int'(rem), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy after release", int'(busy), 0);

    // R10 extremes
    run(0, 7, 0, 1'b1);
    chk("R10 zero quot", int'($signed(quot)), 0);
    chk("R10 zero rem", int'($signed(rem)), 0);
    run(-9, 9, 0, 1'b1);
    chk("R10 neg-Y quot", int'($signed(quot)), -(1 << P) + 1);
    chk("R10 neg-Y rem", int'($signed(rem)), -9);

    // R3 R4 R5 exhaustive sweep
    for (int y = 1; y < (1 << N); y++)
      for (int x = -y; x < y; x++)
        run(x, y, 0, (x == y - 1));

    // R8 outputs hold after done
    hq = int'(quot);
    hr = int'(rem);
    repeat (5) @(negedge clk);
    chk("R8 quot hold", int'(quot), hq);
    chk("R8 rem hold", int'(rem), hr);

    // R6 operand scramble while busy
    run(-5, 11, 1, 1'b1);
    run(6, 13, 1, 1'b1);

    // R7 start while busy ignored, no second operation
    run(-3, 7, 2, 1'b1);
    extra = 0;
    for (int k = 0; k < P + 4; k++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk("R7 no second operation", extra, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule